// File: doc/BRIEF.md
# Prioritized Operand Forwarding Unit

This block chooses, for each of the two ALU operands of the execute stage in a five-stage pipeline, where the operand value comes from. The three sources are the value read from the register file, the ALU result held in the execute/memory pipeline register, and the final value held in the memory/write-back pipeline register. Both operands use the same rules, and each is decided on its own. When both later stages would supply the same register, the younger producer wins. That producer is the one in execute/memory. This matters in chains that rewrite one register on consecutive instructions.

A second output asks the pipeline to hold when the instruction about to enter execute is a load and the instruction behind it reads the loaded register. Forwarding alone cannot satisfy that case, because the loaded value exists only after the memory stage. All outputs are registered. The pipeline feeds the block the values that its pipeline registers are about to capture. The selects are then valid during the same cycle in which those registers hold the instruction.

Top module: `fwd_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, both selects read 00 and the stall request reads 0.
- R2: An operand select becomes 10 (execute/memory result) when that stage's write enable is 1, its destination is nonzero, and its destination equals the operand's source specifier.
- R3: An operand select becomes 01 (write-back value) when the write-back write enable is 1, its destination is nonzero and equals the source, and the R2 condition is false for that operand.
- R4: When both the execute/memory and the write-back stages match a source, the select is 10. In the chain add r1,r1,r2 ; sub r1,r1,r3 ; or r1,r4,r1, the or therefore takes the sub result.
- R5: A source specifier of 0 always gives select 00, whatever the destinations and write enables are.
- R6: A stage whose write enable is 0 never supplies an operand, even when its destination matches.
- R7: Operand A and operand B are decided independently, with identical rules. The select value 11 never appears.
- R8: The stall request is 1 when the instruction entering execute is a load, its destination is nonzero, and that destination equals either source of the instruction entering decode.
- R9: The stall request is 0 when the instruction entering execute is not a load, or when the load destination is register 0.
- R10: Each output shows the decision for the inputs sampled at the previous rising clock edge, and it holds that value until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ex_src_a | input | 3 | Source specifier of operand A for the instruction entering execute |
| ex_src_b | input | 3 | Source specifier of operand B for the instruction entering execute |
| ex_is_load | input | 1 | The instruction entering execute is a load |
| ex_dst | input | 3 | Destination of the instruction entering execute |
| mem_we | input | 1 | Register write enable of the instruction entering memory |
| mem_dst | input | 3 | Destination of the instruction entering memory |
| wb_we | input | 1 | Register write enable of the instruction entering write-back |
| wb_dst | input | 3 | Destination of the instruction entering write-back |
| id_src_a | input | 3 | First source of the instruction entering decode |
| id_src_b | input | 3 | Second source of the instruction entering decode |
| sel_a | output | 2 | Operand A select: 00 register file, 10 execute/memory, 01 write-back |
| sel_b | output | 2 | Operand B select, same encoding as sel_a |
| stall_req | output | 1 | Load-use hold request |

## Verification
Every output is due exactly one rising edge after its inputs are presented. The bench changes inputs on the falling edge and compares the outputs at the following falling edge, so each comparison sees the decision for exactly one input vector. One directed check samples just after a new vector is driven. At that point the outputs must still show the previous decision. The forwarding sweep covers every combination of source, destination and enable for both operands, and the stall sweep covers every load, destination and source combination.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } sel_e;

    typedef struct packed {
        sel_e sel_a;
        sel_e sel_b;
        logic stall;
    } fwd_state_t;

endpackage

// File: rtl/fwd_operand_pick.sv
module fwd_operand_pick #(
    parameter int REG_W = 3
) (
    input  logic [REG_W-1:0] src,
    input  logic             mem_we,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             wb_we,
    input  logic [REG_W-1:0] wb_dst,
    output fwd_pkg::sel_e    sel
);
    logic mem_hit;
    logic wb_hit;

    always_comb begin
        mem_hit = mem_we && (mem_dst != '0) && (mem_dst == src);
        wb_hit  = wb_we  && (wb_dst  != '0) && (wb_dst  == src);
        if (mem_hit)
            sel = fwd_pkg::SEL_MEM;   // youngest producer first
        else if (wb_hit)
            sel = fwd_pkg::SEL_WB;
        else
            sel = fwd_pkg::SEL_RF;
    end
endmodule

// File: rtl/fwd_load_guard.sv
module fwd_load_guard #(
    parameter int REG_W = 3
) (
    input  logic             ld,
    input  logic [REG_W-1:0] ld_dst,
    input  logic [REG_W-1:0] nxt_a,
    input  logic [REG_W-1:0] nxt_b,
    output logic             hold
);
    always_comb begin
        hold = ld && (ld_dst != '0) && ((ld_dst == nxt_a) || (ld_dst == nxt_b));
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit #(
    parameter int REG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] ex_src_a,
    input  logic [REG_W-1:0] ex_src_b,
    input  logic             ex_is_load,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             mem_we,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             wb_we,
    input  logic [REG_W-1:0] wb_dst,
    input  logic [REG_W-1:0] id_src_a,
    input  logic [REG_W-1:0] id_src_b,
    output logic [1:0]       sel_a,
    output logic [1:0]       sel_b,
    output logic             stall_req
);
    localparam int N_OPS = 2;

    fwd_pkg::fwd_state_t state_d, state_q;

    logic [N_OPS-1:0][REG_W-1:0] srcs;
    fwd_pkg::sel_e               picks [N_OPS];
    logic                        hold;

    assign srcs[0] = ex_src_a;
    assign srcs[1] = ex_src_b;

    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        fwd_operand_pick #(.REG_W(REG_W)) u_pick (
            .src     (srcs[g]),
            .mem_we  (mem_we),
            .mem_dst (mem_dst),
            .wb_we   (wb_we),
            .wb_dst  (wb_dst),
            .sel     (picks[g])
        );
    end

    fwd_load_guard #(.REG_W(REG_W)) u_guard (
        .ld     (ex_is_load),
        .ld_dst (ex_dst),
        .nxt_a  (id_src_a),
        .nxt_b  (id_src_b),
        .hold   (hold)
    );

    always_comb begin
        state_d       = state_q;
        state_d.sel_a = picks[0];
        state_d.sel_b = picks[1];
        state_d.stall = hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '{sel_a: fwd_pkg::SEL_RF, sel_b: fwd_pkg::SEL_RF, stall: 1'b0};
        else
            state_q <= state_d;
    end

    assign sel_a     = state_q.sel_a;
    assign sel_b     = state_q.sel_b;
    assign stall_req = state_q.stall;
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
    parameter int REG_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] ex_src_a,
    input logic [REG_W-1:0] ex_src_b,
    input logic             ex_is_load,
    input logic [REG_W-1:0] ex_dst,
    input logic             mem_we,
    input logic [REG_W-1:0] mem_dst,
    input logic             wb_we,
    input logic [REG_W-1:0] wb_dst,
    input logic [REG_W-1:0] id_src_a,
    input logic [REG_W-1:0] id_src_b,
    input logic [1:0]       sel_a,
    input logic [1:0]       sel_b,
    input logic             stall_req
);
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (sel_a == 2'b00 && sel_b == 2'b00 && !stall_req));

    a_r2_mem_fwd_a: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_dst != '0 && mem_dst == ex_src_a) |=> (sel_a == 2'b10));

    a_r3_wb_fwd_b: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_we && wb_dst != '0 && wb_dst == ex_src_b &&
         !(mem_we && mem_dst == ex_src_b)) |=> (sel_b == 2'b01));

    a_r5_zero_src: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_src_a == '0) |=> (sel_a == 2'b00));

    a_r6_no_we: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we && !wb_we) |=> (sel_a == 2'b00 && sel_b == 2'b00));

    a_r7_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_a) && $onehot0(sel_b));

    a_r8_load_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_is_load && ex_dst != '0 && (ex_dst == id_src_a || ex_dst == id_src_b))
        |=> stall_req);

    a_r9_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_is_load || ex_dst == '0) |=> !stall_req);
endmodule

bind fwd_unit fwd_unit_chk #(.REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ex_src_a   (ex_src_a),
    .ex_src_b   (ex_src_b),
    .ex_is_load (ex_is_load),
    .ex_dst     (ex_dst),
    .mem_we     (mem_we),
    .mem_dst    (mem_dst),
    .wb_we      (wb_we),
    .wb_dst     (wb_dst),
    .id_src_a   (id_src_a),
    .id_src_b   (id_src_b),
    .sel_a      (sel_a),
    .sel_b      (sel_b),
    .stall_req  (stall_req)
);

// File: tb/test_fwd_unit.sv
module test_fwd_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ex_src_a = '0, ex_src_b = '0, ex_dst = '0;
    logic       ex_is_load = 1'b0, mem_we = 1'b0, wb_we = 1'b0;
    logic [2:0] mem_dst = '0, wb_dst = '0, id_src_a = '0, id_src_b = '0;
    logic [1:0] sel_a, sel_b;
    logic       stall_req;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    fwd_unit #(.REG_W(3)) i_fwd_unit (
        .clk(clk), .rst_n(rst_n),
        .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
        .ex_is_load(ex_is_load), .ex_dst(ex_dst),
        .mem_we(mem_we), .mem_dst(mem_dst),
        .wb_we(wb_we), .wb_dst(wb_dst),
        .id_src_a(id_src_a), .id_src_b(id_src_b),
        .sel_a(sel_a), .sel_b(sel_b), .stall_req(stall_req)
    );

    function automatic logic [1:0] exp_sel(input logic [2:0] s, input logic mw,
                                           input logic [2:0] md, input logic ww,
                                           input logic [2:0] wd);
        if (s == 0) return 2'b00;
        if (mw && md == s) return 2'b10;
        if (ww && wd == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic string tag_of(input logic [2:0] s, input logic mw,
                                     input logic [2:0] md, input logic ww,
                                     input logic [2:0] wd);
        bit mh = mw && md == s;
        bit wh = ww && wd == s;
        if (s == 0) return "R5";
        if (mh && wh) return "R4";
        if (mh) return "R2";
        if (wh) return "R3";
        if (md == s || wd == s) return "R6";
        return "R7";
    endfunction

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_up();
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check("R1", sel_a, 2'b00);
        check("R1", sel_b, 2'b00);
        check("R1", {1'b0, stall_req}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", sel_a, 2'b00);
        check("R1", {1'b0, stall_req}, 2'b00);

        // R4: or r1,r4,r1 after sub r1 (mem) and add r1 (wb): operand B takes 10
        ex_src_a = 3'd4; ex_src_b = 3'd1;
        mem_we = 1'b1; mem_dst = 3'd1; wb_we = 1'b1; wb_dst = 3'd1;
        @(negedge clk);
        check("R4", sel_b, 2'b10);
        check("R4", sel_a, 2'b00);

        // R10: new inputs must not show until the next rising edge
        ex_src_a = 3'd1;
        #2;
        check("R10", sel_a, 2'b00);
        @(negedge clk);
        check("R10", sel_a, 2'b10);

        // R2 R3 R4 R5 R6 R7: full forwarding sweep
        for (int sa = 0; sa < 8; sa++)
            for (int sb = 0; sb < 8; sb++)
                for (int md = 0; md < 8; md++)
                    for (int mw = 0; mw < 2; mw++)
                        for (int wd = 0; wd < 8; wd++)
                            for (int ww = 0; ww < 2; ww++) begin
                                ex_src_a = 3'(sa); ex_src_b = 3'(sb);
                                mem_dst = 3'(md); mem_we = 1'(mw);
                                wb_dst = 3'(wd); wb_we = 1'(ww);
                                @(negedge clk);
                                check(tag_of(3'(sa), 1'(mw), 3'(md), 1'(ww), 3'(wd)),
                                      sel_a, exp_sel(3'(sa), 1'(mw), 3'(md), 1'(ww), 3'(wd)));
                                // R7: operand B uses the same rules on its own source
                                check("R7", sel_b,
                                      exp_sel(3'(sb), 1'(mw), 3'(md), 1'(ww), 3'(wd)));
                            end

        // R8 R9: load-use stall sweep
        mem_we = 1'b0; wb_we = 1'b0;
        for (int ld = 0; ld < 2; ld++)
            for (int d = 0; d < 8; d++)
                for (int a = 0; a < 8; a++)
                    for (int b = 0; b < 8; b++) begin
                        logic e;
                        ex_is_load = 1'(ld); ex_dst = 3'(d);
                        id_src_a = 3'(a); id_src_b = 3'(b);
                        e = (ld == 1) && (d != 0) && (d == a || d == b);
                        @(negedge clk);
                        check(e ? "R8" : "R9", {1'b0, stall_req}, {1'b0, e});
                    end

        done = 1'b1;
        finish_up();
    end
endmodule